// File: doc/BRIEF.md
# DAC Register Controller with Deferred Update

This block sits behind a serial-bus receiver in front of a 10-bit voltage DAC. The receiver hands it bytes that it has already acknowledged, each tagged by role: control byte, low data byte or high data byte. It also passes on the bus events START, STOP and the acknowledge of the shared SYNC quick command together with that command's flag bit. The block keeps a pending set of registers (control bits and a 10-bit code) and an applied set of registers. The applied set drives the DAC code, the shutdown output and the reference-select output.

A word sequencer assembles the incoming bytes. It has three states. `ST_IDLE` means no transfer is in progress. `ST_CMD` means a control byte has been taken and a low byte is expected. `ST_LOW` means the low byte is held and the high byte is expected. Its transitions are:
- ctrl-byte: any state goes to `ST_CMD`.
- low-byte: `ST_CMD` goes to `ST_LOW`.
- high-byte: `ST_LOW` goes to `ST_IDLE` and commits the 10-bit code.
- abort: START, STOP or a clear from any state returns to `ST_IDLE`.

A byte of the wrong role for the current state is dropped. The applied set copies the pending set at one of two moments, chosen by the pending sync-mode bit. With the bit clear, the copy happens at STOP. With the bit set, it happens at a SYNC acknowledge whose flag is 1. Several converters can therefore change output together.

Top module: `dac_latch_ctrl`

## Requirements
- R1: While reset is held, and right after it, `dac_code` is 0, `pd_hiz` is 0 and `ref_internal` is 0. All pending registers are also 0, so a STOP right after reset keeps the outputs at 0.
- R2: In a control byte, bit 0 is sync mode, bit 1 is shutdown and bit 2 is internal reference. Bits 7 to 3 have no effect. The applied shutdown bit drives `pd_hiz`, and the applied reference bit drives `ref_internal`.
- R3: The code is built from the low data byte (code bits 7..0) and bits 1..0 of the high data byte (code bits 9..8). Bits 7..2 of the high byte are ignored. Data bytes that do not follow an accepted control byte in the order low then high are ignored. Tag encoding on `byte_kind`: 0 = control, 1 = low data, 2 = high data, 3 = ignored.
- R4: With pending sync mode 0, the outputs change only in the clock cycle after a STOP, and they then equal the pending registers.
- R5: With pending sync mode 1, STOP leaves the outputs unchanged. A SYNC acknowledge with flag 1 copies the pending set to the outputs.
- R6: A SYNC acknowledge with flag 1 has no effect when pending sync mode is 0.
- R7: A SYNC acknowledge with flag 0 clears pending and applied registers and aborts any partial word, whatever the sync mode.
- R8: A START or STOP after the control byte but before the high byte keeps the new control bits and leaves the pending code unchanged.
- R9: A control byte sent alone (followed directly by STOP) changes the control bits only; the code stays as it was.
- R10: In shutdown, `pd_hiz` is 1 and `dac_code` still presents the applied code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe for an acknowledged byte |
| byte_kind | input | 2 | Role of the byte (0 control, 1 low, 2 high) |
| byte_data | input | 8 | Byte value |
| start_evt | input | 1 | START or repeated START seen |
| stop_evt | input | 1 | STOP seen |
| sync_ack | input | 1 | Acknowledge of the SYNC quick command |
| sync_flag | input | 1 | Flag bit of that SYNC command |
| dac_code | output | 10 | Applied DAC code |
| pd_hiz | output | 1 | Applied shutdown (output to high impedance) |
| ref_internal | output | 1 | Applied reference select, 1 = internal |

## Verification
The pending registers cannot be seen at the ports. A fault in them, or in the sequencer, shows up only when a STOP or a SYNC acknowledge copies them out, and it appears one cycle after that event. The tests therefore always follow a write with an update event and then read the outputs. A wrong update trigger shows up one cycle after a STOP or SYNC that should have left the outputs alone. A clear that misses the pending set shows up only at the next STOP.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
    localparam int CODE_W = 10;
    localparam int BYTE_W = 8;
    localparam int HI_W   = CODE_W - BYTE_W;

    // bit positions inside the control byte (decoded here)
    localparam int SY_BIT = 0;
    localparam int SD_BIT = 1;
    localparam int BG_BIT = 2;

    typedef enum logic [1:0] {
        KIND_CTRL = 2'd0,
        KIND_LO   = 2'd1,
        KIND_HI   = 2'd2
    } byte_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_LOW  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic bg;
        logic sd;
        logic sy;
    } ctrl_t;
endpackage

// File: rtl/dac_word_seq.sv
module dac_word_seq
    import dac_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [1:0]        byte_kind,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              abort,
    input  logic              clear,
    output ctrl_t             pend_ctrl,
    output logic [CODE_W-1:0] pend_code
);
    seq_state_t        state, state_nx;
    logic [BYTE_W-1:0] lo_hold;
    logic              take;

    assign take = byte_valid && !abort && !clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (clear || abort) begin
            state_nx = ST_IDLE;
        end else if (byte_valid) begin
            if (byte_kind == KIND_CTRL) begin
                state_nx = ST_CMD;
            end else begin
                unique case (state)
                    ST_CMD:  if (byte_kind == KIND_LO) state_nx = ST_LOW;
                    ST_LOW:  if (byte_kind == KIND_HI) state_nx = ST_IDLE;
                    default: state_nx = state;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_ctrl <= '0;
            pend_code <= '0;
            lo_hold   <= '0;
        end else if (clear) begin
            pend_ctrl <= '0;
            pend_code <= '0;
            lo_hold   <= '0;
        end else if (take) begin
            if (byte_kind == KIND_CTRL) begin
                pend_ctrl.sy <= byte_data[SY_BIT];
                pend_ctrl.sd <= byte_data[SD_BIT];
                pend_ctrl.bg <= byte_data[BG_BIT];
            end
            if (byte_kind == KIND_LO && state == ST_CMD)
                lo_hold <= byte_data;
            if (byte_kind == KIND_HI && state == ST_LOW)
                pend_code <= {byte_data[HI_W-1:0], lo_hold};
        end
    end
endmodule

// File: rtl/dac_out_latch.sv
module dac_out_latch
    import dac_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             pend_ctrl,
    input  logic [CODE_W-1:0] pend_code,
    input  logic              stop_evt,
    input  logic              sync_upd,
    input  logic              clear,
    output logic [CODE_W-1:0] out_code,
    output logic              out_pd,
    output logic              out_ref
);
    logic apply;

    assign apply = (stop_evt && !pend_ctrl.sy) || (sync_upd && pend_ctrl.sy);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_code <= '0;
            out_pd   <= 1'b0;
            out_ref  <= 1'b0;
        end else if (clear) begin
            out_code <= '0;
            out_pd   <= 1'b0;
            out_ref  <= 1'b0;
        end else if (apply) begin
            out_code <= pend_code;
            out_pd   <= pend_ctrl.sd;
            out_ref  <= pend_ctrl.bg;
        end
    end
endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
    import dac_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [1:0]        byte_kind,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sync_ack,
    input  logic              sync_flag,
    output logic [CODE_W-1:0] dac_code,
    output logic              pd_hiz,
    output logic              ref_internal
);
    ctrl_t             pend_ctrl;
    logic [CODE_W-1:0] pend_code;
    logic              clr_all;
    logic              sync_upd;

    assign clr_all  = sync_ack && !sync_flag;
    assign sync_upd = sync_ack && sync_flag;

    dac_word_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_kind  (byte_kind),
        .byte_data  (byte_data),
        .abort      (start_evt || stop_evt),
        .clear      (clr_all),
        .pend_ctrl  (pend_ctrl),
        .pend_code  (pend_code)
    );

    dac_out_latch u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_ctrl (pend_ctrl),
        .pend_code (pend_code),
        .stop_evt  (stop_evt),
        .sync_upd  (sync_upd),
        .clear     (clr_all),
        .out_code  (dac_code),
        .out_pd    (pd_hiz),
        .out_ref   (ref_internal)
    );
endmodule

// File: rtl/dac_latch_ctrl_chk.sv
module dac_latch_ctrl_chk
    import dac_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              stop_evt,
    input logic              sync_ack,
    input logic              sync_flag,
    input logic              pend_sy,
    input logic [CODE_W-1:0] dac_code,
    input logic              pd_hiz,
    input logic              ref_internal
);
    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_ZERO: assert (dac_code == '0 && !pd_hiz && !ref_internal); // R1
        end
    end

    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_evt || sync_ack) |=> ($stable(dac_code) && $stable(pd_hiz) && $stable(ref_internal))); // R4

    AST_STOP_BLOCKED_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !sync_ack && pend_sy) |=> ($stable(dac_code) && $stable(pd_hiz) && $stable(ref_internal))); // R5

    AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ack && sync_flag && !stop_evt && !pend_sy) |=> ($stable(dac_code) && $stable(pd_hiz) && $stable(ref_internal))); // R6

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ack && !sync_flag) |=> (dac_code == '0 && !pd_hiz && !ref_internal)); // R7
endmodule

bind dac_latch_ctrl dac_latch_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_evt     (stop_evt),
    .sync_ack     (sync_ack),
    .sync_flag    (sync_flag),
    .pend_sy      (pend_ctrl.sy),
    .dac_code     (dac_code),
    .pd_hiz       (pd_hiz),
    .ref_internal (ref_internal)
);

// File: tb/dac_latch_ctrl_bench.sv
module dac_latch_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [1:0] byte_kind = 2'd0;
    logic [7:0] byte_data = 8'd0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       sync_ack = 1'b0;
    logic       sync_flag = 1'b0;
    logic [9:0] dac_code;
    logic       pd_hiz;
    logic       ref_internal;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    logic [9:0] e_code = '0;
    logic       e_pd = 1'b0;
    logic       e_ref = 1'b0;

    always #5 clk = ~clk;

    dac_latch_ctrl u_dac_latch_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_kind(byte_kind),
        .byte_data(byte_data), .start_evt(start_evt), .stop_evt(stop_evt),
        .sync_ack(sync_ack), .sync_flag(sync_flag), .dac_code(dac_code),
        .pd_hiz(pd_hiz), .ref_internal(ref_internal)
    );

    task automatic check(input string req);
        n_chk++;
        if (dac_code !== e_code || pd_hiz !== e_pd || ref_internal !== e_ref) begin
            n_fail++;
            $display("FAIL %s: got code=%0d pd=%0b ref=%0b, expected code=%0d pd=%0b ref=%0b",
                     req, dac_code, pd_hiz, ref_internal, e_code, e_pd, e_ref);
        end
    endtask

    task automatic put_byte(input logic [1:0] k, input logic [7:0] d);
        @(negedge clk);
        byte_valid = 1'b1; byte_kind = k; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic do_sync(input logic flag);
        @(negedge clk); sync_ack = 1'b1; sync_flag = flag;
        @(negedge clk); sync_ack = 1'b0; sync_flag = 1'b0;
    endtask

    // full word, high byte upper bits set to junk (must be ignored, R3)
    task automatic put_word(input logic [7:0] ctl, input logic [9:0] code);
        put_byte(2'd0, ctl);
        put_byte(2'd1, code[7:0]);
        put_byte(2'd2, {6'b101101, code[9:8]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        do_stop();
        check("R1 stop after reset");

        // sweep of every control-bit combination, with junk upper bits
        for (int c = 0; c < 16; c++) begin
            logic [7:0] ctl;
            logic [9:0] code;
            ctl  = {(c[3] ? 5'b10110 : 5'b01001), c[2:0]};
            code = 10'((c * 197 + 3) % 1024);
            put_word(ctl, code);
            check("R4 outputs held before update");
            do_stop();
            if (!ctl[0]) begin
                e_code = code; e_pd = ctl[1]; e_ref = ctl[2];
                check("R2 R4 R10 stop applies word");
            end else begin
                check("R5 stop ignored in sync mode");
                do_sync(1'b1);
                e_code = code; e_pd = ctl[1]; e_ref = ctl[2];
                check("R2 R5 R10 sync applies word");
            end
        end

        // code sweep, normal mode
        for (int v = 0; v < 1024; v += 33) begin
            put_word(8'h00, 10'(v));
            do_stop();
            e_code = 10'(v); e_pd = 1'b0; e_ref = 1'b0;
            check("R3 code assembly");
        end
        put_word(8'h00, 10'd1023);
        do_stop();
        e_code = 10'd1023;
        check("R3 full-scale code");

        // R6: sync with flag 1 in stop mode does nothing
        put_word(8'h00, 10'd100);
        do_stop();
        e_code = 10'd100;
        check("R4 baseline");
        put_word(8'h00, 10'd200);
        do_sync(1'b1);
        check("R6 sync ignored in stop mode");
        do_stop();
        e_code = 10'd200;
        check("R4 stop applies after ignored sync");

        // R8: interrupted words
        put_byte(2'd0, 8'h04);
        put_byte(2'd1, 8'h55);
        do_stop();
        e_ref = 1'b1;
        check("R8 stop after low byte keeps control drops data");
        put_byte(2'd0, 8'h00);
        put_byte(2'd1, 8'h11);
        do_start();
        put_byte(2'd2, 8'h03);
        do_stop();
        e_ref = 1'b0;
        check("R8 start before high byte drops data");

        // R9: control byte alone
        put_byte(2'd0, 8'h02);
        do_stop();
        e_pd = 1'b1;
        check("R9 R10 control only, code kept in shutdown");

        // R3: stray data bytes without control byte
        put_byte(2'd1, 8'h12);
        put_byte(2'd2, 8'h01);
        do_stop();
        check("R3 stray data ignored");

        // R7: clear in sync mode
        put_word(8'h07, 10'h3AB);
        do_sync(1'b1);
        e_code = 10'h3AB; e_pd = 1'b1; e_ref = 1'b1;
        check("R5 sync update before clear");
        do_sync(1'b0);
        e_code = '0; e_pd = 1'b0; e_ref = 1'b0;
        check("R7 clear in sync mode");
        do_stop();
        check("R7 pending cleared too");

        // R7: clear in stop mode, and mid-word
        put_word(8'h04, 10'h155);
        do_stop();
        e_code = 10'h155; e_ref = 1'b1;
        check("R4 word before clear");
        put_byte(2'd0, 8'h06);
        put_byte(2'd1, 8'h77);
        do_sync(1'b0);
        e_code = '0; e_ref = 1'b0;
        check("R7 clear in stop mode");
        put_byte(2'd2, 8'h03);
        do_stop();
        check("R7 partial word aborted by clear");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule